// File: doc/BRIEF.md
# Infrared Envelope Pulse-Width Capture

This block times the marks and spaces of an already demodulated infrared envelope. A free-running divider turns the reference clock into receive ticks, and a pulse timer counts those ticks between two qualifying envelope edges. Each finished interval is written into a small receive queue as a word that carries the interval length, the envelope level during the interval and a valid flag. A host reads the queue one word per pop strobe and watches a small status vector and an interrupt line.

If no qualifying edge arrives before the timer wraps, the block records an end-of-activity word of all ones and raises a sticky timeout flag. When the queue is full a new interval is dropped and a sticky overrun flag is raised. The two sticky flags are cleared by taking the receiver enable or the queue enable low, not by a write. The read side is a valid/ready stream: `rd_word[TIMER_W-1]` is the valid flag, `rd_pop` is the ready, and a word is consumed on a clock edge where both are high. The queue holds its contents for as long as the reader does not pop. Back-pressure never stalls the timer. Intervals that arrive while the queue is full are lost and counted only through the overrun flag.

Top module: `irw_capture`

## Requirements
- R1: After reset `rd_word`, `status` and `irq` are all zero.
- R2: For two qualifying edges N clocks apart with divider value D, the stored count in `rd_word[TIMER_W-3:0]` is floor(floor(N/(D+1))/4). The timer advances once every D+1 clocks and only its upper TIMER_W-2 bits are kept.
- R3: `rd_word[TIMER_W-2]` holds the envelope level that lasted during the measured interval. `rd_word[TIMER_W-1]` is 1 exactly when the queue holds a word.
- R4: `edge_sel` picks the qualifying edges: 0 none, 1 falling only, 2 rising only, 3 both. The first qualifying edge after idle only starts the timer and stores nothing.
- R5: If the timer wraps with no qualifying edge, a word with all count and level bits set is stored, timeout status bit 0 is set and the timer returns to idle.
- R6: With `no_marker` high a wrap still sets the timeout bit but stores no word.
- R7: The queue holds DEPTH words (default 8) in arrival order. A word arriving while it is full is dropped and sets overrun status bit 1.
- R8: A pop with the queue empty leaves the queue unchanged, and later words are read back correctly.
- R9: Service status bit 4 is set when the queue holds at least DEPTH/2 words with `wm_not_empty` low, or at least one word with `wm_not_empty` high.
- R10: Overrun stays set until `fifo_en` is low for a clock, which also empties the queue. Timeout stays set until `rx_en` is low for a clock.
- R11: Status bit 2 is high while the timer is running. Status bit 3 is always 0.
- R12: `irq` is the OR of timeout AND `ie_timeout`, overrun AND `ie_overrun`, and service AND `ie_service`.
- R13: Taking `rx_en` low stops and clears the timer. The next qualifying edge then only restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_in | input | 1 | Demodulated envelope |
| rx_en | input | 1 | Receiver enable; low clears timer and timeout |
| fifo_en | input | 1 | Queue enable; low empties queue and clears overrun |
| edge_sel | input | 2 | Qualifying edge select |
| wm_not_empty | input | 1 | Service watermark select |
| no_marker | input | 1 | Suppress the end-of-activity word |
| tick_div | input | DIV_W | Tick period minus one, in clocks |
| ie_timeout | input | 1 | Interrupt enable for timeout |
| ie_overrun | input | 1 | Interrupt enable for overrun |
| ie_service | input | 1 | Interrupt enable for service request |
| rd_pop | input | 1 | Read ready; consumes the head word |
| rd_word | output | TIMER_W | {valid, level, count} of the head word |
| status | output | 5 | {service, 0, busy, overrun, timeout} |
| irq | output | 1 | Interrupt request |

## Verification
An envelope change reaches `rd_word` two rising edges later: one edge samples the envelope, and the next stores the word. Timeout, overrun and busy follow their event by one edge. Service and `irq` follow the queue count and enables with no extra register. The bench changes inputs only on falling edges and reads results at least two falling edges after the last envelope change. Timeout is checked once well before the wrap is due and once well after it.

// File: rtl/irw_pkg.sv
package irw_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  localparam int ST_TMO = 0;
  localparam int ST_OVR = 1;
  localparam int ST_BSY = 2;
  localparam int ST_SVC = 4;
  localparam int ST_W   = 5;
endpackage

// File: rtl/irw_tick_gen.sv
module irw_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || !run)  cnt <= '0;
    else if (cnt == div)       cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  // a tick is followed by at least div idle clocks
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && !restart) |=> (!tick || div == '0));
endmodule

// File: rtl/irw_pulse_timer.sv
module irw_pulse_timer
  import irw_pkg::*;
#(
  parameter int TIMER_W = 18,
  parameter int DIV_W   = 16,
  localparam int CNT_W  = TIMER_W - 2,
  localparam int ENT_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             env_in,
  input  logic [1:0]       edge_sel,
  input  logic             no_marker,
  input  logic [DIV_W-1:0] tick_div,
  output logic             push,
  output logic [ENT_W-1:0] push_data,
  output logic             wrap_evt,
  output logic             running
);
  logic             env_q, env_prev;
  logic             rise, fall, sel_hit, hit;
  logic             tick, carry, hi_full, overflow;
  logic [1:0]       lo;
  logic [CNT_W-1:0] hi, cap_hi;
  edge_mode_e       mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      env_q    <= 1'b0;
      env_prev <= 1'b0;
    end else begin
      env_q    <= env_in;
      env_prev <= env_q;
    end
  end

  assign rise = env_q & ~env_prev;
  assign fall = ~env_q & env_prev;
  assign mode = edge_mode_e'(edge_sel);

  always_comb begin
    unique case (mode)
      EDGE_OFF:  sel_hit = 1'b0;
      EDGE_FALL: sel_hit = fall;
      EDGE_RISE: sel_hit = rise;
      EDGE_ANY:  sel_hit = rise | fall;
      default:   sel_hit = 1'b0;
    endcase
  end

  assign hit = rx_en && sel_hit;

  irw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .restart (hit),
    .div     (tick_div),
    .tick    (tick)
  );

  assign carry    = tick && (lo == 2'd3);
  assign hi_full  = &hi;
  assign overflow = running && !hit && carry && hi_full;
  assign cap_hi   = (carry && !hi_full) ? hi + 1'b1 : hi;

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      running <= 1'b0;
      lo      <= '0;
      hi      <= '0;
    end else if (hit) begin
      running <= 1'b1;
      lo      <= '0;
      hi      <= '0;
    end else if (overflow) begin
      running <= 1'b0;
      lo      <= '0;
      hi      <= '0;
    end else if (running && tick) begin
      lo <= lo + 1'b1;
      if (lo == 2'd3) hi <= hi + 1'b1;
    end
  end

  assign push      = (hit && running) || (overflow && !no_marker);
  assign push_data = overflow ? '1 : {env_prev, cap_hi};
  assign wrap_evt  = overflow;

  p_idle_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!running && hi == '0 && lo == '0));

  p_start_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(hit));
endmodule

// File: rtl/irw_rx_fifo.sv
module irw_rx_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             drop
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             wr_ok, rd_ok, full, empty;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = en && push && !full;
  assign rd_ok = en && pop && !empty;
  assign drop  = en && push && full;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rd_ptr];

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pop && empty) |=> (rd_ptr == $past(rd_ptr)));
endmodule

// File: rtl/irw_capture.sv
module irw_capture
  import irw_pkg::*;
#(
  parameter int TIMER_W = 18,
  parameter int DIV_W   = 16,
  parameter int DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               env_in,
  input  logic               rx_en,
  input  logic               fifo_en,
  input  logic [1:0]         edge_sel,
  input  logic               wm_not_empty,
  input  logic               no_marker,
  input  logic [DIV_W-1:0]   tick_div,
  input  logic               ie_timeout,
  input  logic               ie_overrun,
  input  logic               ie_service,
  input  logic               rd_pop,
  output logic [TIMER_W-1:0] rd_word,
  output logic [4:0]         status,
  output logic               irq
);
  localparam int ENT_W = TIMER_W - 1;
  localparam int QC_W  = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  logic             push, wrap_evt, busy, drop, tmo, ovr, svc;
  logic [ENT_W-1:0] push_data, head;
  logic [QC_W-1:0]  qcount;

  irw_pulse_timer #(.TIMER_W(TIMER_W), .DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .env_in    (env_in),
    .edge_sel  (edge_sel),
    .no_marker (no_marker),
    .tick_div  (tick_div),
    .push      (push),
    .push_data (push_data),
    .wrap_evt  (wrap_evt),
    .running   (busy)
  );

  irw_rx_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (fifo_en),
    .push  (push),
    .din   (push_data),
    .pop   (rd_pop),
    .dout  (head),
    .count (qcount),
    .drop  (drop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) tmo <= 1'b0;
    else if (wrap_evt)    tmo <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fifo_en) ovr <= 1'b0;
    else if (drop)          ovr <= 1'b1;
  end

  assign svc = wm_not_empty ? (qcount != '0) : (qcount >= QC_W'(HALF));

  always_comb begin
    status         = '0;
    status[ST_TMO] = tmo;
    status[ST_OVR] = ovr;
    status[ST_BSY] = busy;
    status[ST_SVC] = svc;
  end

  assign rd_word = (qcount != '0) ? {1'b1, head} : '0;
  assign irq     = (tmo & ie_timeout) | (ovr & ie_overrun) | (svc & ie_service);

  p_tmo_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && rx_en) |=> tmo);

  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && fifo_en) |=> ovr);

  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(qcount == QC_W'(DEPTH)));
endmodule

// File: tb/irw_capture_test.sv
module irw_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW  = 10;
  localparam int DW  = 4;
  localparam int DEP = 8;
  localparam int CW  = TW - 2;

  logic          clk = 1'b0;
  logic          rst_n, env_in, rx_en, fifo_en, wm_not_empty, no_marker;
  logic [1:0]    edge_sel;
  logic [DW-1:0] tick_div;
  logic          ie_timeout, ie_overrun, ie_service, rd_pop;
  logic [TW-1:0] rd_word;
  logic [4:0]    status;
  logic          irq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irw_capture #(.TIMER_W(TW), .DIV_W(DW), .DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n), .env_in(env_in), .rx_en(rx_en), .fifo_en(fifo_en),
    .edge_sel(edge_sel), .wm_not_empty(wm_not_empty), .no_marker(no_marker),
    .tick_div(tick_div), .ie_timeout(ie_timeout), .ie_overrun(ie_overrun),
    .ie_service(ie_service), .rd_pop(rd_pop), .rd_word(rd_word),
    .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop(output logic [TW-1:0] w);
    w = rd_word;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic rx_reset();
    rx_en = 1'b0; step(1); rx_en = 1'b1; step(1);
  endtask

  task automatic flush();
    fifo_en = 1'b0; step(1); fifo_en = 1'b1; step(1);
  endtask

  function automatic int cnt_of(input logic [TW-1:0] w);
    return int'(w[CW-1:0]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [TW-1:0] w;
    logic lvl;
    rst_n = 0; env_in = 0; rx_en = 0; fifo_en = 0; edge_sel = 2'd3;
    wm_not_empty = 0; no_marker = 0; tick_div = '0;
    ie_timeout = 0; ie_overrun = 0; ie_service = 0; rd_pop = 0;
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 rd_word", int'(rd_word), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);
    rx_en = 1; fifo_en = 1;

    // R2/R3 sweep over divider and interval length, both edges
    for (int d = 0; d < 4; d++) begin
      tick_div = DW'(d);
      for (int i = 0; i < 10; i++) begin
        int n;
        n = 3 + 7 * i;
        rx_reset(); flush();
        env_in = ~env_in; lvl = env_in;
        step(n);
        env_in = ~env_in;
        step(2);
        pop(w);
        chk("R2 count", cnt_of(w), (n / (d + 1)) >> 2);
        chk("R3 level", int'(w[CW]), int'(lvl));
        chk("R3 valid", int'(w[CW+1]), 1);
      end
    end

    // R4 first edge only starts, R11 busy
    tick_div = '0;
    rx_reset(); flush();
    env_in = ~env_in; step(3);
    chk("R4 start only", int'(rd_word[CW+1]), 0);
    chk("R11 busy", int'(status[2]), 1);
    chk("R11 bit3", int'(status[3]), 0);

    // R4 rising only
    edge_sel = 2'd2; env_in = 0; step(2); rx_reset(); flush();
    env_in = 1; step(5); env_in = 0; step(7);
    chk("R4 rise ignores fall", int'(rd_word[CW+1]), 0);
    env_in = 1; step(2);
    pop(w);
    chk("R4 rise count", cnt_of(w), 3);
    chk("R4 rise level", int'(w[CW]), 0);

    // R4 falling only
    edge_sel = 2'd1; env_in = 1; step(2); rx_reset(); flush();
    env_in = 0; step(9); env_in = 1; step(11); env_in = 0; step(2);
    pop(w);
    chk("R4 fall count", cnt_of(w), 5);
    chk("R4 fall level", int'(w[CW]), 1);

    // R4 edge select off
    edge_sel = 2'd0; rx_reset(); flush();
    env_in = ~env_in; step(4); env_in = ~env_in; step(4); env_in = ~env_in; step(3);
    chk("R4 off valid", int'(rd_word[CW+1]), 0);
    chk("R4 off busy", int'(status[2]), 0);

    // R5 wrap marker
    edge_sel = 2'd3; rx_reset(); flush();
    env_in = ~env_in; step(1000);
    chk("R5 no early timeout", int'(status[0]), 0);
    chk("R11 busy long", int'(status[2]), 1);
    step(40);
    chk("R5 timeout", int'(status[0]), 1);
    chk("R5 idle after wrap", int'(status[2]), 0);
    chk("R5 marker", int'(rd_word), (1 << TW) - 1);

    // R12 interrupt combine, R9 watermark with one word
    for (int m = 0; m < 8; m++) begin
      for (int wm = 0; wm < 2; wm++) begin
        int s;
        ie_timeout = m[0]; ie_overrun = m[1]; ie_service = m[2];
        wm_not_empty = wm[0];
        #1;
        s = wm;
        chk("R9 svc one word", int'(status[4]), s);
        chk("R12 irq", int'(irq), m[0] | (m[2] & s));
      end
    end
    ie_timeout = 0; ie_overrun = 0; ie_service = 0; wm_not_empty = 0;
    step(1);

    pop(w);
    chk("R10 timeout sticky", int'(status[0]), 1);
    rx_reset();
    chk("R10 timeout cleared", int'(status[0]), 0);

    // R6 suppressed marker
    no_marker = 1; flush();
    env_in = ~env_in; step(1040);
    chk("R6 timeout", int'(status[0]), 1);
    chk("R6 no word", int'(rd_word[CW+1]), 0);
    no_marker = 0;

    // R7/R9 fill, overrun
    rx_reset(); flush();
    env_in = ~env_in; lvl = env_in;
    for (int k = 1; k <= 11; k++) begin
      int c, e;
      step(2);
      c = k - 1;
      e = (c > DEP) ? DEP : c;
      chk("R3 valid fill", int'(rd_word[CW+1]), int'(e > 0));
      wm_not_empty = 0; #1;
      chk("R9 svc half", int'(status[4]), int'(e >= DEP / 2));
      wm_not_empty = 1; #1;
      chk("R9 svc any", int'(status[4]), int'(e > 0));
      wm_not_empty = 0;
      chk("R7 overrun", int'(status[1]), int'(c > DEP));
      if (k < 11) begin
        step(6);
        env_in = ~env_in;
      end
    end
    ie_overrun = 1; #1;
    chk("R12 irq overrun", int'(irq), 1);
    ie_overrun = 0;
    for (int j = 0; j < DEP; j++) begin
      pop(w);
      chk("R7 order count", cnt_of(w), 2);
      chk("R7 order level", int'(w[CW]), int'(lvl ^ j[0]));
    end
    pop(w);
    chk("R7 dropped", int'(w[CW+1]), 0);
    chk("R10 overrun sticky", int'(status[1]), 1);
    flush();
    chk("R10 overrun cleared", int'(status[1]), 0);

    // R8 empty pops
    rx_reset(); flush();
    for (int j = 0; j < 3; j++) begin
      pop(w);
      chk("R8 empty pop", int'(w[CW+1]), 0);
    end
    env_in = ~env_in; step(12); env_in = ~env_in; step(2);
    pop(w);
    chk("R8 after empty pops", cnt_of(w), 3);
    step(5); env_in = ~env_in; step(16); env_in = ~env_in; step(2);
    pop(w);
    chk("R7 first", cnt_of(w), 2);
    pop(w);
    chk("R7 second", cnt_of(w), 4);
    pop(w);
    chk("R8 drained", int'(w[CW+1]), 0);

    // R13 disable mid-interval
    rx_reset(); flush();
    env_in = ~env_in; step(20);
    rx_en = 0; step(1);
    chk("R13 idle", int'(status[2]), 0);
    rx_en = 1; step(3);
    env_in = ~env_in; step(2);
    chk("R13 restart only", int'(rd_word[CW+1]), 0);
    chk("R13 busy again", int'(status[2]), 1);
    step(10); env_in = ~env_in; step(2);
    pop(w);
    chk("R13 fresh count", cnt_of(w), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule